// File: doc/BRIEF.md
# SPI Byte Exchange Data Path

This block is the byte data path of a serial peripheral link that can act as either end of the link. The CPU side sees two locations on a small register bus: a status location and a data location. Writing the data location puts the byte straight into the serial shifter. There is no holding stage in front of the shifter. Reading the data location returns a separate receive copy that is refreshed only when a byte completes.

During a transfer the local shifter and the partner's shifter act as a single sixteen-bit ring. Eight shift steps swap their contents. In master mode a data write starts the byte. The block drives SS low and issues eight SCK periods, each 2*DIV_HALF system clocks long. In slave mode the block watches the incoming SCK and SS through synchronizers and counts bit steps only while SS is low.

Two sticky flags report events. The done flag marks a completed byte. The collision flag marks a data write that arrived while a byte was moving. Both flags clear when software reads the status location and then accesses the data location.

Top module: `spi_xchg`

## Requirements
- R1: One transfer moves exactly eight bits. Afterwards the master's receive copy holds the byte the slave had loaded, and the slave's receive copy holds the byte the master had loaded.
- R2: The link runs in mode 0 with the most significant bit first. SCK idles low, the data line carries bit 7 before the first rising SCK edge, bits are sampled on rising edges, and the data line changes after falling edges.
- R3: A data write (reg_sel=1, wr_en=1) made while idle loads the shifter directly. In master mode it starts the transfer, and SS is low in the cycle after the write.
- R4: Reads of the data location return the receive copy. This copy changes only when a byte completes, so during a transfer a read returns the previous byte.
- R5: With reg_sel=0, rdata is the status byte: bit 7 is the done flag, bit 6 is the collision flag, and the other bits are 0. The done flag sets when the eighth bit step completes.
- R6: A data-location access (read or write) clears both flags only if a status read (rd_en=1, reg_sel=0) came before it. A data read made without that status read leaves the flags set.
- R7: A data write made while a byte is moving sets the collision flag and leaves the shifter untouched, so the byte in flight is delivered unchanged.
- R8: The master produces exactly eight SCK periods of 2*DIV_HALF clocks. It holds SS low from the cycle after the write until DIV_HALF clocks after the last falling SCK edge, which is 17*DIV_HALF cycles in total.
- R9: The slave counts SCK edges only while SS is low. If SS rises partway through a byte, the bit count restarts and no done flag is raised. In slave mode the shifter's top bit is presented on miso_o.
- R10: Reset clears both flags, drives SCK low and drives SS high. Reset leaves the receive copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| is_master | input | 1 | 1 = master, 0 = slave |
| reg_sel | input | 1 | 0 = status location, 1 = data location |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the flag-clear sequence) |
| wdata | input | W | Write data |
| rdata | output | W | Read data for the location chosen by reg_sel |
| xfer_done | output | 1 | Byte-complete flag |
| wr_collide | output | 1 | Write-collision flag |
| sck_o | output | 1 | SCK driven in master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| mosi_o | output | 1 | Master serial data out |
| miso_o | output | 1 | Slave serial data out |
| sck_i | input | 1 | SCK received in slave mode |
| ss_n_i | input | 1 | Active-low select received in slave mode |
| mosi_i | input | 1 | Serial data received in slave mode |
| miso_i | input | 1 | Serial data received in master mode |

## Verification
The hardest case to reach from the ports is a slave whose select is withdrawn partway through a byte. A real master never does this. To reach it, the bench takes over the slave's pins from the master instance. It clocks three bits, raises SS, reloads the slave, and then clocks a full byte while capturing miso_o. A bit counter that failed to restart would raise the done flag early and deliver a misaligned byte. A collision is reached by issuing a second data write about twenty cycles into a master transfer. The bench then checks that the partner still receives the first byte.

// File: rtl/spi_xchg_pkg.sv
package spi_xchg_pkg;
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_RUN  = 2'd1,
    MS_TAIL = 2'd2
  } mseq_e;

  localparam int unsigned STAT_DONE_OFS = 1;  // status bit W-1
  localparam int unsigned STAT_COLL_OFS = 2;  // status bit W-2
endpackage

// File: rtl/spi_xchg_rst.sv
module spi_xchg_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/spi_xchg_sync.sv
module spi_xchg_sync #(
  parameter int unsigned   W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/spi_xchg_mseq.sv
module spi_xchg_mseq
  import spi_xchg_pkg::*;
#(
  parameter int unsigned HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last_bit,
  output logic sck,
  output logic ss_n,
  output logic rise,
  output logic fall,
  output logic busy
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(HALF - 1);

  mseq_e         st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          sck_q, sck_n;
  logic          half_end;

  assign half_end = (cnt_q == CNT_END);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sck_n = sck_q;
    rise  = 1'b0;
    fall  = 1'b0;
    unique case (st_q)
      MS_IDLE: begin
        if (start) begin
          st_n  = MS_RUN;
          cnt_n = '0;
          sck_n = 1'b0;
        end
      end
      MS_RUN: begin
        if (half_end) begin
          cnt_n = '0;
          if (!sck_q) begin
            sck_n = 1'b1;
            rise  = 1'b1;
          end else begin
            sck_n = 1'b0;
            fall  = 1'b1;
            if (last_bit) st_n = MS_TAIL;
          end
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      MS_TAIL: begin
        if (half_end) begin
          st_n  = MS_IDLE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      default: begin
        st_n  = MS_IDLE;
        cnt_n = '0;
        sck_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_IDLE;
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sck_q <= sck_n;
    end
  end

  assign sck  = sck_q;
  assign ss_n = (st_q == MS_IDLE);
  assign busy = (st_q != MS_IDLE);
endmodule

// File: rtl/spi_xchg_shreg.sv
module spi_xchg_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_d,
  input  logic         sample,
  input  logic         shift,
  input  logic         ser_in,
  input  logic         cnt_clr,
  output logic         msb,
  output logic         last_bit,
  output logic         done,
  output logic [W-1:0] sh,
  output logic [W-1:0] rx
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  sh_q, sh_n;
  logic [W-1:0]  rx_q;
  logic          samp_q;

  assign last_bit = (cnt_q == CNT_LAST);
  assign done     = shift & last_bit;

  always_comb begin
    cnt_n = cnt_q;
    if (cnt_clr || load)  cnt_n = '0;
    else if (shift)       cnt_n = last_bit ? '0 : cnt_q + CW'(1);
  end

  always_comb begin
    sh_n = sh_q;
    if (load)       sh_n = load_d;
    else if (shift) sh_n = {sh_q[W-2:0], samp_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // Data storage is deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (sample) samp_q <= ser_in;
    if (load || shift) sh_q <= sh_n;
    if (done) rx_q <= sh_n;
  end

  assign msb = sh_q[W-1];
  assign sh  = sh_q;
  assign rx  = rx_q;
endmodule

// File: rtl/spi_xchg_flags.sv
module spi_xchg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic coll,
  input  logic st_rd,
  input  logic dat_acc,
  output logic spif,
  output logic wcol,
  output logic clr
);
  logic arm_q, arm_n;
  logic spif_q, spif_n;
  logic wcol_q, wcol_n;

  assign clr = dat_acc & arm_q;

  always_comb begin
    arm_n  = arm_q;
    if (st_rd)        arm_n = 1'b1;
    else if (dat_acc) arm_n = 1'b0;
    spif_n = done | (spif_q & ~clr);
    wcol_n = coll | (wcol_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      spif_q <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      arm_q  <= arm_n;
      spif_q <= spif_n;
      wcol_q <= wcol_n;
    end
  end

  assign spif = spif_q;
  assign wcol = wcol_q;
endmodule

// File: rtl/spi_xchg.sv
module spi_xchg
  import spi_xchg_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned DIV_HALF = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         is_master,
  input  logic         reg_sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         xfer_done,
  output logic         wr_collide,
  output logic         sck_o,
  output logic         ss_n_o,
  output logic         mosi_o,
  output logic         miso_o,
  input  logic         sck_i,
  input  logic         ss_n_i,
  input  logic         mosi_i,
  input  logic         miso_i
);
  localparam int unsigned PIN_N = 4;

  logic rst_n_i;
  logic [PIN_N-1:0] pins_s;
  logic sck_s, ss_s, mosi_s, miso_s;
  logic sck_d_q;
  logic slv_act, s_rise, s_fall;
  logic m_sck, m_ss_n, m_rise, m_fall, m_busy;
  logic busy, dat_wr, dat_rd, st_rd, load, coll, start;
  logic sample, shift, ser_in, cnt_clr;
  logic msb, last_bit, done;
  logic [W-1:0] sh_q, rx_q;
  logic spif, wcol, clr;

  spi_xchg_rst u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_i)
  );

  spi_xchg_sync #(.W(PIN_N), .RST_VAL(4'b0100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({sck_i, ss_n_i, mosi_i, miso_i}),
    .q     (pins_s)
  );

  assign sck_s  = pins_s[3];
  assign ss_s   = pins_s[2];
  assign mosi_s = pins_s[1];
  assign miso_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sck_d_q <= 1'b0;
    else          sck_d_q <= sck_s;
  end

  assign slv_act = ~is_master & ~ss_s;
  assign s_rise  = slv_act &  sck_s & ~sck_d_q;
  assign s_fall  = slv_act & ~sck_s &  sck_d_q;

  assign busy   = is_master ? m_busy : slv_act;
  assign dat_wr = wr_en & reg_sel;
  assign dat_rd = rd_en & reg_sel;
  assign st_rd  = rd_en & ~reg_sel;
  assign load   = dat_wr & ~busy;
  assign coll   = dat_wr & busy;
  assign start  = is_master & load;

  assign sample  = is_master ? m_rise : s_rise;
  assign shift   = is_master ? m_fall : s_fall;
  assign ser_in  = is_master ? miso_s : mosi_s;
  assign cnt_clr = ~is_master & ss_s;

  spi_xchg_mseq #(.HALF(DIV_HALF)) u_mseq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (start),
    .last_bit (last_bit),
    .sck      (m_sck),
    .ss_n     (m_ss_n),
    .rise     (m_rise),
    .fall     (m_fall),
    .busy     (m_busy)
  );

  spi_xchg_shreg #(.W(W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (load),
    .load_d   (wdata),
    .sample   (sample),
    .shift    (shift),
    .ser_in   (ser_in),
    .cnt_clr  (cnt_clr),
    .msb      (msb),
    .last_bit (last_bit),
    .done     (done),
    .sh       (sh_q),
    .rx       (rx_q)
  );

  spi_xchg_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .done    (done),
    .coll    (coll),
    .st_rd   (st_rd),
    .dat_acc (dat_wr | dat_rd),
    .spif    (spif),
    .wcol    (wcol),
    .clr     (clr)
  );

  always_comb begin
    rdata = '0;
    if (reg_sel) begin
      rdata = rx_q;
    end else begin
      rdata[W-STAT_DONE_OFS] = spif;
      rdata[W-STAT_COLL_OFS] = wcol;
    end
  end

  assign xfer_done  = spif;
  assign wr_collide = wcol;
  assign sck_o      = m_sck;
  assign ss_n_o     = m_ss_n;
  assign mosi_o     = msb;
  assign miso_o     = msb;
endmodule

// File: rtl/spi_xchg_chk.sv
module spi_xchg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         is_master,
  input logic         sck_o,
  input logic         ss_n_o,
  input logic         spif,
  input logic         wcol,
  input logic         done,
  input logic         clr,
  input logic         coll,
  input logic         load,
  input logic         shift,
  input logic [W-1:0] sh_q,
  input logic [W-1:0] rx_q
);
  logic [3:0] rcnt_q;
  logic       sck_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q  <= '0;
      sck_p_q <= 1'b0;
    end else begin
      sck_p_q <= sck_o;
      if (ss_n_o)                rcnt_q <= '0;
      else if (sck_o && !sck_p_q) rcnt_q <= rcnt_q + 4'd1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) ss_n_o |-> !sck_o); // R8
  AST_EIGHT_SCK_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (is_master && $rose(ss_n_o)) |-> (rcnt_q == 4'd8)); // R8
  AST_RX_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_q) |-> $past(done)); // R4
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) done |=> spif); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (spif && !clr) |=> spif); // R6
  AST_COLLIDE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) coll |=> wcol); // R7
  AST_SHIFTER_GUARDED: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sh_q) |-> $past(load || shift)); // R7
endmodule

bind spi_xchg spi_xchg_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .is_master (is_master),
  .sck_o     (sck_o),
  .ss_n_o    (ss_n_o),
  .spif      (spif),
  .wcol      (wcol),
  .done      (done),
  .clr       (clr),
  .coll      (coll),
  .load      (load),
  .shift     (shift),
  .sh_q      (sh_q),
  .rx_q      (rx_q)
);

// File: tb/spi_xchg_tb.sv
`timescale 1ns/1ps
module spi_xchg_tb;
  localparam int HALF = 8;
  localparam int SS_LOW = 17 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       m_sel = 1'b0, m_wr = 1'b0, m_rd = 1'b0;
  logic [7:0] m_wd = '0, m_rdata;
  logic       p_sel = 1'b0, p_wr = 1'b0, p_rd = 1'b0;
  logic [7:0] p_wd = '0, p_rdata;
  logic       m_done, m_coll, p_done, p_coll;
  logic       m_sck, m_ss_n, m_mosi, m_miso_unused;
  logic       p_sck_unused, p_ss_unused, p_mosi_unused, p_miso;
  logic       man = 1'b0, tb_sck = 1'b0, tb_ss = 1'b1, tb_mosi = 1'b0;
  logic       pk_sck, pk_ss, pk_mosi;

  assign pk_sck  = man ? tb_sck  : m_sck;
  assign pk_ss   = man ? tb_ss   : m_ss_n;
  assign pk_mosi = man ? tb_mosi : m_mosi;

  spi_xchg #(.W(8), .DIV_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .reg_sel(m_sel),
    .wr_en(m_wr), .rd_en(m_rd), .wdata(m_wd), .rdata(m_rdata),
    .xfer_done(m_done), .wr_collide(m_coll),
    .sck_o(m_sck), .ss_n_o(m_ss_n), .mosi_o(m_mosi), .miso_o(m_miso_unused),
    .sck_i(1'b0), .ss_n_i(1'b1), .mosi_i(1'b0), .miso_i(p_miso)
  );

  spi_xchg #(.W(8), .DIV_HALF(HALF)) u_peer (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .reg_sel(p_sel),
    .wr_en(p_wr), .rd_en(p_rd), .wdata(p_wd), .rdata(p_rdata),
    .xfer_done(p_done), .wr_collide(p_coll),
    .sck_o(p_sck_unused), .ss_n_o(p_ss_unused), .mosi_o(p_mosi_unused), .miso_o(p_miso),
    .sck_i(pk_sck), .ss_n_i(pk_ss), .mosi_i(pk_mosi), .miso_i(1'b0)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Master-side pin monitor
  logic       mon_sck_p = 1'b0, mon_ss_p = 1'b1;
  int         mon_rises = 0, mon_low = 0;
  logic [7:0] mon_bits = '0;
  always @(negedge clk) begin
    if (!m_ss_n && mon_ss_p) begin
      mon_rises = 0;
      mon_low   = 1;
      mon_bits  = '0;
    end else if (!m_ss_n) begin
      mon_low = mon_low + 1;
    end
    if (m_sck && !mon_sck_p) begin
      mon_rises = mon_rises + 1;
      mon_bits  = {mon_bits[6:0], m_mosi};
    end
    mon_sck_p = m_sck;
    mon_ss_p  = m_ss_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit peer, input bit sel, input bit wr, input bit rd, input logic [7:0] d);
    @(negedge clk);
    if (peer) begin p_sel = sel; p_wr = wr; p_rd = rd; p_wd = d; end
    else      begin m_sel = sel; m_wr = wr; m_rd = rd; m_wd = d; end
    @(negedge clk);
    if (peer) begin p_wr = 1'b0; p_rd = 1'b0; end
    else      begin m_wr = 1'b0; m_rd = 1'b0; end
  endtask

  task automatic peek(input bit peer, input bit sel, output logic [7:0] v);
    @(negedge clk);
    if (peer) p_sel = sel; else m_sel = sel;
    #1;
    v = peer ? p_rdata : m_rdata;
  endtask

  task automatic clear_flags(input bit peer);
    bus(peer, 1'b0, 1'b0, 1'b1, 8'h00);
    bus(peer, 1'b1, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic wait_idle();
    while (!m_ss_n) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] mb, input logic [7:0] sb, input bit pv, input logic [7:0] psb);
    logic [7:0] v;
    bus(1'b1, 1'b1, 1'b1, 1'b0, sb);
    bus(1'b0, 1'b1, 1'b1, 1'b0, mb);
    chk("R3 ss low after write", int'(m_ss_n), 0);
    repeat (40) @(negedge clk);
    if (pv) begin
      peek(1'b0, 1'b1, v);
      chk("R4 rx mid-transfer", int'(v), int'(psb));
    end
    peek(1'b0, 1'b0, v);
    chk("R5 status mid-transfer", int'(v), 8'h00);
    wait_idle();
    peek(1'b0, 1'b1, v);
    chk("R1 master rx", int'(v), int'(sb));
    peek(1'b1, 1'b1, v);
    chk("R1 slave rx", int'(v), int'(mb));
    chk("R2 mosi msb-first", int'(mon_bits), int'(mb));
    chk("R8 sck count", mon_rises, 8);
    chk("R8 ss low cycles", mon_low, SS_LOW);
    peek(1'b0, 1'b0, v);
    chk("R5 master status", int'(v), 8'h80);
    peek(1'b1, 1'b0, v);
    chk("R5 slave status", int'(v), 8'h80);
    bus(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    peek(1'b0, 1'b0, v);
    chk("R6 no clear without status read", int'(v), 8'h80);
    clear_flags(1'b0);
    clear_flags(1'b1);
    peek(1'b0, 1'b0, v);
    chk("R6 master cleared", int'(v), 8'h00);
    peek(1'b1, 1'b0, v);
    chk("R6 slave cleared", int'(v), 8'h00);
  endtask

  task automatic sbit(input logic b, inout logic [7:0] cap);
    tb_mosi = b;
    repeat (HALF) @(negedge clk);
    cap = {cap[6:0], p_miso};
    tb_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    tb_sck = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] v, psb, cap;
    logic [7:0] tgt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    peek(1'b0, 1'b0, v);
    chk("R10 status after reset", int'(v), 8'h00);
    chk("R10 ss high", int'(m_ss_n), 1);
    chk("R10 sck low", int'(m_sck), 0);

    // R1/R2/R3/R4/R5/R6/R8 exhaustive sweep over master bytes
    psb = '0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] sb;
      sb = 8'((i * 37 + 91) & 255);
      xfer(8'(i), sb, i > 0, psb);
      psb = sb;
    end

    // R7 collision
    bus(1'b1, 1'b1, 1'b1, 1'b0, 8'h5A);
    bus(1'b0, 1'b1, 1'b1, 1'b0, 8'hC3);
    repeat (20) @(negedge clk);
    bus(1'b0, 1'b1, 1'b1, 1'b0, 8'h0F);
    wait_idle();
    peek(1'b0, 1'b0, v);
    chk("R7 collision status", int'(v), 8'hC0);
    peek(1'b1, 1'b1, v);
    chk("R7 slave got original", int'(v), 8'hC3);
    chk("R7 mosi original", int'(mon_bits), 8'hC3);
    peek(1'b0, 1'b1, v);
    chk("R7 master rx", int'(v), 8'h5A);

    // R10 reset keeps data, clears flags
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    peek(1'b0, 1'b0, v);
    chk("R10 flags cleared", int'(v), 8'h00);
    peek(1'b0, 1'b1, v);
    chk("R10 rx retained", int'(v), 8'h5A);
    peek(1'b1, 1'b1, v);
    chk("R10 slave rx retained", int'(v), 8'hC3);

    // R9 slave abort mid-byte
    man = 1'b1;
    repeat (8) @(negedge clk);
    tb_ss = 1'b0;
    cap = '0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 3; k++) sbit(1'b1, cap);
    repeat (4) @(negedge clk);
    tb_ss = 1'b1;
    repeat (8) @(negedge clk);
    peek(1'b1, 1'b0, v);
    chk("R9 no done after partial byte", int'(v), 8'h00);
    bus(1'b1, 1'b1, 1'b1, 1'b0, 8'h3C);
    tb_ss = 1'b0;
    repeat (HALF) @(negedge clk);
    cap = '0;
    tgt = 8'hA5;
    for (int k = 7; k >= 0; k--) sbit(tgt[k], cap);
    repeat (HALF) @(negedge clk);
    tb_ss = 1'b1;
    repeat (8) @(negedge clk);
    peek(1'b1, 1'b1, v);
    chk("R9 slave rx after restart", int'(v), 8'hA5);
    chk("R9 slave miso byte", int'(cap), 8'h3C);
    peek(1'b1, 1'b0, v);
    chk("R9 slave done", int'(v), 8'h80);
    man = 1'b0;

    finish_run();
  end
endmodule